// File: doc/BRIEF.md
# Iterative 32x32 Multiplier with Selectable Result Half

The block multiplies two 32-bit operands over a fixed sequence of clock cycles and returns one 32-bit word: the low half of the product, or the high half under one of three sign conventions. These are unsigned by unsigned, signed A by unsigned B, and signed by signed. A 6-bit extended opcode chooses the result. A separate immediate-select flag swaps operand B for a sign-extended 16-bit immediate and forces a low-half multiply.

One shift loop runs for 32 steps. In each step it updates a low-half accumulator, working from the top multiplier bit down. In the same step it updates an unsigned high-half accumulator, working from the bottom multiplier bit up. After the loop, one extra cycle turns the unsigned high half into the signed forms with up to two subtractions and registers the chosen word. The caller pulses `start_i` while the block is idle, then waits for the one-cycle `done_o` pulse.

Top module: `imul_iter`

## Requirements
- R1: After reset `busy_o` is 0, `done_o` is 0 and `result_o` is 0.
- R2: A `start_i` sampled high while idle raises `busy_o` at the next edge. `done_o` rises at the 33rd clock edge after the edge that sampled `start_i`.
- R3: `done_o` is high for exactly one cycle per operation, and `busy_o` is low in that cycle. A new start is accepted in that same cycle.
- R4: With `imm_sel_i`=0 and `opx_i`=0x27, the result is bits 31:0 of A*B.
- R5: With `imm_sel_i`=0 and `opx_i`=0x07, the result is bits 63:32 of the unsigned product A*B.
- R6: With `imm_sel_i`=0 and `opx_i`=0x17, the result is bits 63:32 of A*B, with A read as two's complement and B as unsigned.
- R7: With `imm_sel_i`=0 and `opx_i`=0x1f, the result is bits 63:32 of A*B, with both operands read as two's complement.
- R8: With `imm_sel_i`=1, the result is bits 31:0 of A times `imm_i` sign-extended to 32 bits. `opb_i` and `opx_i` have no effect.
- R9: With `imm_sel_i`=0 and any `opx_i` other than 0x27, 0x07 or 0x17, the block performs the R7 operation.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its original operands, and no extra `done_o` pulse follows.
- R11: `result_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| opa_i | input | 32 | Operand A (multiplicand) |
| opb_i | input | 32 | Operand B (multiplier) |
| imm_i | input | 16 | Immediate used in place of B |
| imm_sel_i | input | 1 | Select immediate form |
| opx_i | input | 6 | Extended opcode choosing the result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 32 | Selected 32-bit result, held until the next done |

## Verification
Some properties are checked on every cycle, independent of operand values. These are the single-cycle `done_o` pulse, that `done_o` and `busy_o` are never high together, that `result_o` holds outside the finishing cycle, that an idle start raises busy, and that a start during a run keeps the loop running. One more checks that both multiplier shift copies are empty when the loop ends. The numeric results of each opcode, the immediate sign extension, the fallback for unlisted opcodes, and the exact 33-edge latency depend on data. Only the bench's scenarios show those, through its 64-bit reference model and done-cycle bookkeeping.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    SEL_LO = 2'd0,
    SEL_UU = 2'd1,
    SEL_SU = 2'd2,
    SEL_SS = 2'd3
  } imul_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } imul_state_e;

  localparam logic [5:0] OPX_LO = 6'h27;
  localparam logic [5:0] OPX_UU = 6'h07;
  localparam logic [5:0] OPX_SU = 6'h17;
endpackage

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned IMMW = 16,
  parameter int unsigned OPXW = 6
) (
  input  logic [W-1:0]    opb_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            imm_sel_i,
  input  logic [OPXW-1:0] opx_i,
  output imul_sel_e       sel_o,
  output logic [W-1:0]    b_eff_o
);
  localparam int unsigned EXTW = W - IMMW;

  logic [W-1:0] imm_ext;
  assign imm_ext = {{EXTW{imm_i[IMMW-1]}}, imm_i};

  always_comb begin
    if (imm_sel_i) begin
      sel_o   = SEL_LO;
      b_eff_o = imm_ext;
    end else begin
      b_eff_o = opb_i;
      case (opx_i)
        OPX_LO:  sel_o = SEL_LO;
        OPX_UU:  sel_o = SEL_UU;
        OPX_SU:  sel_o = SEL_SU;
        default: sel_o = SEL_SS;  // unlisted codes fall to signed x signed
      endcase
    end
  end
endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl
  import imul_pkg::*;
#(
  parameter int unsigned STEPS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  imul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
          cnt_d   = '0;
        end
      end
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_busy_ignores_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i) |=> (step_o || fix_o));

  p_fix_follows_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |-> $past(step_o));
endmodule

// File: rtl/imul_core.sv
module imul_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic [W-1:0] a_q, b_q, lo_q, hi_q, ml_q, mr_q;
  logic [W-1:0] lo_n, hi_n;
  logic [W:0]   hi_sum;

  // low half: shift first, then add on top multiplier bit
  assign lo_n = (lo_q << 1) + (ml_q[W-1] ? a_q : '0);
  // high half: add on bottom multiplier bit, then shift right keeping carry
  assign hi_sum = {1'b0, hi_q} + {1'b0, (mr_q[0] ? a_q : '0)};
  assign hi_n   = W'(hi_sum >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      lo_q <= '0;
      hi_q <= '0;
      ml_q <= '0;
      mr_q <= '0;
    end else if (load_i) begin
      a_q  <= a_i;
      b_q  <= b_i;
      lo_q <= '0;
      hi_q <= '0;
      ml_q <= b_i;
      mr_q <= b_i;
    end else if (step_i) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      ml_q <= ml_q << 1;
      mr_q <= mr_q >> 1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
  assign a_o  = a_q;
  assign b_o  = b_q;

  p_mult_drained_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_i) |-> (ml_q == '0 && mr_q == '0));
endmodule

// File: rtl/imul_fix.sv
module imul_fix
  import imul_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         fix_i,
  input  imul_sel_e    sel_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  imul_sel_e    sel_q;
  logic [W-1:0] su, ss, pick;

  assign su = hi_i - (a_i[W-1] ? b_i : '0);
  assign ss = su   - (b_i[W-1] ? a_i : '0);

  always_comb begin
    unique case (sel_q)
      SEL_LO:  pick = lo_i;
      SEL_UU:  pick = hi_i;
      SEL_SU:  pick = su;
      default: pick = ss;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_LO;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (load_i) sel_q <= sel_i;
      if (fix_i) result_o <= pick;
      done_o <= fix_i;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_i |=> $stable(result_o));
endmodule

// File: rtl/imul_iter.sv
module imul_iter
  import imul_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned IMMW = 16,
  parameter int unsigned OPXW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [W-1:0]    opa_i,
  input  logic [W-1:0]    opb_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            imm_sel_i,
  input  logic [OPXW-1:0] opx_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [W-1:0]    result_o
);
  imul_sel_e    sel;
  logic [W-1:0] b_eff, lo, hi, a_l, b_l;
  logic         load, step, fix;

  imul_decode #(.W(W), .IMMW(IMMW), .OPXW(OPXW)) u_dec (
    .opb_i(opb_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i), .opx_i(opx_i),
    .sel_o(sel), .b_eff_o(b_eff)
  );

  imul_ctrl #(.STEPS(W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .step_o(step), .fix_o(fix), .busy_o(busy_o)
  );

  imul_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .a_i(opa_i), .b_i(b_eff),
    .lo_o(lo), .hi_o(hi), .a_o(a_l), .b_o(b_l)
  );

  imul_fix #(.W(W)) u_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .fix_i(fix),
    .sel_i(sel), .lo_i(lo), .hi_i(hi), .a_i(a_l), .b_i(b_l),
    .result_o(result_o), .done_o(done_o)
  );

  p_done_not_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/imul_iter_test.sv
module imul_iter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        imm_sel = 1'b0;
  logic [5:0]  opx = '0;
  logic        busy, done;
  logic [31:0] result;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0, mon_on = 0;
  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imul_iter uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opa_i(opa), .opb_i(opb),
    .imm_i(imm), .imm_sel_i(imm_sel), .opx_i(opx),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [15:0] im, logic isel, logic [5:0] x);
    logic [63:0] ua, ub, sa, sb, p;
    logic [31:0] bb;
    bb = isel ? {{16{im[15]}}, im} : b;
    ua = {32'b0, a};  sa = {{32{a[31]}}, a};
    ub = {32'b0, bb}; sb = {{32{bb[31]}}, bb};
    if (isel || x == 6'h27) begin p = ua * ub; return p[31:0]; end
    if (x == 6'h07) p = ua * ub;
    else if (x == 6'h17) p = sa * ub;
    else p = sa * sb;
    return p[63:32];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, logic isel, logic [5:0] x);
    @(negedge clk);
    while (busy) @(negedge clk);
    opa = a; opb = b; imm = im; imm_sel = isel; opx = x; start = 1'b1;
    exp_q.push_back(model(a, b, im, isel, x));
    due_q.push_back(cyc + 34);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    // scramble inputs to show they are latched
    opa = ~a; opb = ~b; imm = ~im; opx = ~x;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected done act=%h exp=none", result);
        end else begin
          logic [31:0] e; int d; string t;
          e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
          check(t, result, e);
          check("R2 latency", 32'(cyc), 32'(d));
          check("R3 busy low at done", {31'b0, busy}, 32'd0);
        end
        last_res = result;
      end else begin
        check("R11 hold", result, last_res);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (!finished && cyc > 150000) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R4 low product
    run_op("R4", 32'd43, 32'd7, 16'h0, 1'b0, 6'h27);
    run_op("R4", 32'hdeadbeef, 32'h12345678, 16'h0, 1'b0, 6'h27);
    run_op("R4", 32'hffffffff, 32'hffffffff, 16'h0, 1'b0, 6'h27);
    // R5 unsigned high
    run_op("R5", 32'hffffffff, 32'hffffffff, 16'h0, 1'b0, 6'h07);
    run_op("R5", 32'h80000000, 32'h00000002, 16'h0, 1'b0, 6'h07);
    run_op("R5", 32'h9abcdef0, 32'h87654321, 16'h0, 1'b0, 6'h07);
    // R6 signed x unsigned high
    run_op("R6", 32'hffffffff, 32'h00000005, 16'h0, 1'b0, 6'h17);
    run_op("R6", 32'h80000000, 32'hffffffff, 16'h0, 1'b0, 6'h17);
    run_op("R6", 32'h12345678, 32'hf0000000, 16'h0, 1'b0, 6'h17);
    // R7 signed x signed high
    run_op("R7", 32'h80000000, 32'h80000000, 16'h0, 1'b0, 6'h1f);
    run_op("R7", 32'hffffffff, 32'hffffffff, 16'h0, 1'b0, 6'h1f);
    run_op("R7", 32'h7fffffff, 32'h80000001, 16'h0, 1'b0, 6'h1f);
    // R8 immediate form; opb/opx ignored
    run_op("R8", 32'h00001234, 32'hffffffff, 16'h8000, 1'b1, 6'h07);
    run_op("R8", 32'hfffffffd, 32'h00000000, 16'h7fff, 1'b1, 6'h1f);
    run_op("R8", 32'h80000001, 32'h55555555, 16'hffff, 1'b1, 6'h17);
    // R9 unlisted opcodes behave as signed x signed
    run_op("R9", 32'h80000000, 32'h80000000, 16'h0, 1'b0, 6'h00);
    run_op("R9", 32'hfffffff0, 32'h00000010, 16'h0, 1'b0, 6'h3f);
    run_op("R9", 32'h12345678, 32'hfedcba98, 16'h0, 1'b0, 6'h25);

    // R10 start while busy is ignored
    run_op("R10", 32'h00010001, 32'h00020003, 16'h0, 1'b0, 6'h27);
    repeat (5) @(negedge clk);
    opa = 32'hffffffff; opb = 32'hffffffff; opx = 6'h07; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R3 back-to-back: next start issued in the done cycle
    run_op("R3", 32'h00000003, 32'h00000004, 16'h0, 1'b0, 6'h27);
    run_op("R3", 32'hffffffff, 32'h00000002, 16'h0, 1'b0, 6'h07);

    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check("R10 queue drained", 32'(exp_q.size()), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule